// File: doc/BRIEF.md
# Configurable I2S Serial Audio Transmitter

This block turns stereo sample pairs into a serial audio stream made of a bit clock, a word clock that marks the left and right channel, and one data line. It runs entirely on the system clock. As the clock master it divides the system clock down to a bit clock and counts bit clocks to form the word clock. As a slave it synchronises externally driven bit and word clocks and locks its bit position to the word clock edges.

Static configuration inputs set the role (master or slave), the framing (one bit of delay after the word clock edge, or none), left or right alignment of the sample inside its channel slot, the polarity of both clocks, the sample length and the frame length. The master divider is also set here. A sample pair is offered on a valid/ready handshake and is taken at the start of each frame. A frame with no pair on offer sends zeros and produces an underflow pulse.

Top module: `i2s_tx`

## Requirements
- R1: In master mode `sck_o` has a period of 2 system clocks when `cfg_mdiv4_i`=0 and 4 when it is 1. `clk_oe_o` is 1.
- R2: The word clock period is 32, 64 or 128 bit clocks for `cfg_frame_i` = 0, 1, 2. The left channel slot is the first half of the frame and the right channel slot is the second half.
- R3: With `cfg_ws_inv_i`=0, `ws_o` is low during the left slot and high during the right slot. With 1, the levels are swapped.
- R4: With `cfg_sck_inv_i`=0, `sd_o` changes only on a falling edge of `sck_o`. With 1, it changes only on a rising edge. The receiver samples on the opposite edge.
- R5: With `cfg_i2s_dly_i`=1, the first data bit of a slot appears one bit clock after the word clock edge. With 0, it appears on the same bit clock as the edge.
- R6: With `cfg_rjust_i`=1, the sample ends on the last bit of its slot and the leading bits are zeros. With 0, it starts on the first data bit of the slot.
- R7: `cfg_wlen_i` = 0, 1, 2 selects 16, 24 or 32 bit samples. The sample is taken from bits [len-1:0] of the input word and sent MSB first. Input bits above the length and slot bits outside the sample are sent as 0.
- R8: `smp_ready_o` is high for one system clock at the start of each frame's data. The pair accepted with `smp_valid_i` at that edge is sent in that frame.
- R9: If `smp_valid_i` is low at a frame start, the whole frame carries zeros, and `underflow_o` pulses high for exactly one system clock.
- R10: With `cfg_master_i`=0, `sck_o`, `ws_o` and `clk_oe_o` are 0. Data shifts on edges of `sck_i`. A level change of `ws_i` puts the block at the start of the matching slot. No frame starts before the first such change.
- R11: While `rst_ni` is low, `sd_o`, `underflow_o` and `smp_ready_o` are 0. In master mode `sck_o` equals `cfg_sck_inv_i` and `ws_o` shows the right channel level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, also the master clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_master_i | input | 1 | 1: drive bit and word clocks; 0: follow inputs |
| cfg_i2s_dly_i | input | 1 | One bit clock data delay after word clock edge |
| cfg_rjust_i | input | 1 | Align sample to slot end |
| cfg_ws_inv_i | input | 1 | Word clock polarity |
| cfg_sck_inv_i | input | 1 | Bit clock polarity |
| cfg_wlen_i | input | 2 | Sample length code 0/1/2 = 16/24/32 |
| cfg_frame_i | input | 2 | Frame length code 0/1/2 = 32/64/128 bit clocks |
| cfg_mdiv4_i | input | 1 | Master divider: 0 = /2, 1 = /4 |
| smp_valid_i | input | 1 | Sample pair offered |
| smp_ready_o | output | 1 | Sample pair taken this cycle |
| smp_left_i | input | SMP_W | Left sample |
| smp_right_i | input | SMP_W | Right sample |
| sck_i | input | 1 | External bit clock (slave) |
| ws_i | input | 1 | External word clock (slave) |
| sck_o | output | 1 | Bit clock (master) |
| ws_o | output | 1 | Word clock (master) |
| clk_oe_o | output | 1 | Output enable for both clocks |
| sd_o | output | 1 | Serial data |
| underflow_o | output | 1 | One-cycle pulse on a frame with no sample |

## Verification
The bench builds the block with the default 32-bit sample width, so every sample length code fits into the input word. The full 7-bit bit counter covers all three frame lengths, including 64-bit slots with large zero padding. The bench decodes the serial stream at the receiver's sampling edge for six master configurations. These combine framing delay, right alignment, both polarities, all sample and frame lengths and both dividers. A slave run drives its own bit and word clocks and starts mid-frame, so both the lock and the frame alignment are exercised.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;
  localparam int unsigned FRAME_MAX = 128;
  localparam int unsigned CNT_W     = $clog2(FRAME_MAX);

  typedef logic [CNT_W-1:0] cnt_t;

  // index of the last bit clock in a frame
  function automatic cnt_t frame_last(logic [1:0] sel);
    case (sel)
      2'd0:    return cnt_t'(31);
      2'd1:    return cnt_t'(63);
      default: return cnt_t'(FRAME_MAX - 1);
    endcase
  endfunction

  function automatic logic [5:0] wlen_bits(logic [1:0] sel);
    case (sel)
      2'd0:    return 6'd16;
      2'd1:    return 6'd24;
      default: return 6'd32;
    endcase
  endfunction
endpackage

// File: rtl/i2s_tx_clkgen.sv
module i2s_tx_clkgen #(
  parameter int unsigned SYNC_N = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic master_i,
  input  logic sck_inv_i,
  input  logic mdiv4_i,
  input  logic sck_i,
  input  logic ws_i,
  output logic shift_ev_o,
  output logic sck_o,
  output logic ws_lvl_o
);
  logic raw_q, div_q, tog, s_raw, s_prev_q;
  logic [SYNC_N-1:0] sck_s_q, ws_s_q;

  assign tog = !mdiv4_i || div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_q <= 1'b0;
      div_q <= 1'b0;
    end else if (!master_i) begin
      raw_q <= 1'b0;
      div_q <= 1'b0;
    end else if (tog) begin
      raw_q <= ~raw_q;
      div_q <= 1'b0;
    end else begin
      div_q <= 1'b1;
    end
  end

  // slave side: synchronise external clocks
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_s_q  <= '0;
      ws_s_q   <= '0;
      s_prev_q <= 1'b0;
    end else begin
      sck_s_q  <= {sck_s_q[SYNC_N-2:0], sck_i};
      ws_s_q   <= {ws_s_q[SYNC_N-2:0], ws_i};
      s_prev_q <= s_raw;
    end
  end

  assign s_raw      = sck_s_q[SYNC_N-1] ^ sck_inv_i;
  assign ws_lvl_o   = ws_s_q[SYNC_N-1];
  assign shift_ev_o = master_i ? (tog & raw_q) : (s_prev_q & !s_raw);
  assign sck_o      = master_i ? (raw_q ^ sck_inv_i) : 1'b0;

  AST_SCK_DIV4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && mdiv4_i && $past(master_i && mdiv4_i) && !$stable(raw_q)) |=> $stable(raw_q)); // R1
endmodule

// File: rtl/i2s_tx_framer.sv
module i2s_tx_framer
  import i2s_tx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       shift_ev_i,
  input  logic       master_i,
  input  logic       dly_i,
  input  logic       ws_inv_i,
  input  logic       ws_lvl_i,
  input  logic [1:0] frame_sel_i,
  output logic       ws_o,
  output logic       start_o,
  output logic       active_o,
  output logic       chan_o,
  output cnt_t       pos_o,
  output cnt_t       slot_o
);
  cnt_t last, half, cnt_q, cnt_nxt, g;
  logic chan_q, wsl_q, lock_q, wsl, ws_edge, lock_nxt;

  assign last    = frame_last(frame_sel_i);
  assign half    = (last >> 1) + cnt_t'(1);
  assign wsl     = ws_lvl_i ^ ws_inv_i;
  assign ws_edge = !master_i && (wsl != wsl_q);

  always_comb begin
    if (ws_edge)           cnt_nxt = wsl ? half : '0;
    else if (cnt_q >= last) cnt_nxt = '0;
    else                   cnt_nxt = cnt_q + cnt_t'(1);
    // data position lags the word clock by the framing delay
    if (dly_i && cnt_nxt == '0) g = last;
    else                        g = cnt_nxt - cnt_t'(dly_i);
  end

  assign lock_nxt = master_i | lock_q | ws_edge;
  assign chan_o   = (g >= half);
  assign pos_o    = chan_o ? g - half : g;
  assign slot_o   = half;
  assign active_o = lock_nxt;
  assign start_o  = shift_ev_i & lock_nxt & (g == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '1;
      chan_q <= 1'b1;
      wsl_q  <= 1'b1;
      lock_q <= 1'b0;
    end else if (shift_ev_i) begin
      cnt_q  <= cnt_nxt;
      chan_q <= (cnt_nxt >= half);
      wsl_q  <= wsl;
      lock_q <= lock_nxt;
    end
  end

  assign ws_o = master_i ? (chan_q ^ ws_inv_i) : 1'b0;

  AST_WS_ON_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(chan_q) |-> $past(shift_ev_i)); // R2
  AST_NO_START_UNLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!master_i && !lock_q && !ws_edge) |-> !start_o); // R10
endmodule

// File: rtl/i2s_tx_shifter.sv
module i2s_tx_shifter
  import i2s_tx_pkg::*;
#(
  parameter int unsigned SMP_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             shift_ev_i,
  input  logic             start_i,
  input  logic             active_i,
  input  logic             chan_i,
  input  cnt_t             pos_i,
  input  cnt_t             slot_i,
  input  logic             rjust_i,
  input  logic [1:0]       wlen_sel_i,
  input  logic             valid_i,
  input  logic [SMP_W-1:0] left_i,
  input  logic [SMP_W-1:0] right_i,
  output logic             sd_o,
  output logic             underflow_o
);
  localparam int unsigned IDX_W = (SMP_W > 1) ? $clog2(SMP_W) : 1;

  logic [SMP_W-1:0] cur_l_q, cur_r_q, word;
  logic sd_q, uf_q, bit_d, in_smp;
  int pos, slot, wl, idx;

  always_comb begin
    // new pair bypasses the holding registers on the first bit
    if (start_i) word = valid_i ? (chan_i ? right_i : left_i) : '0;
    else         word = chan_i ? cur_r_q : cur_l_q;
    pos    = int'(pos_i);
    slot   = int'(slot_i);
    wl     = int'(wlen_bits(wlen_sel_i));
    in_smp = 1'b0;
    idx    = 0;
    if (!rjust_i) begin
      if (pos < wl) begin
        idx    = wl - 1 - pos;
        in_smp = 1'b1;
      end
    end else if (pos >= slot - wl) begin
      idx    = slot - 1 - pos;
      in_smp = 1'b1;
    end
    if (idx >= int'(SMP_W)) in_smp = 1'b0;
    bit_d = in_smp & active_i & word[IDX_W'(idx)];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sd_q    <= 1'b0;
      uf_q    <= 1'b0;
      cur_l_q <= '0;
      cur_r_q <= '0;
    end else begin
      uf_q <= start_i & !valid_i;
      if (shift_ev_i) sd_q <= bit_d;
      if (start_i) begin
        cur_l_q <= valid_i ? left_i  : '0;
        cur_r_q <= valid_i ? right_i : '0;
      end
    end
  end

  assign sd_o        = sd_q;
  assign underflow_o = uf_q;

  AST_SD_ON_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sd_q) |-> $past(shift_ev_i)); // R4
  AST_UFLOW_NO_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uf_q |-> $past(!valid_i)); // R9
  AST_UFLOW_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uf_q |=> !uf_q); // R9
endmodule

// File: rtl/i2s_tx.sv
module i2s_tx
  import i2s_tx_pkg::*;
#(
  parameter int unsigned SMP_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_master_i,
  input  logic             cfg_i2s_dly_i,
  input  logic             cfg_rjust_i,
  input  logic             cfg_ws_inv_i,
  input  logic             cfg_sck_inv_i,
  input  logic [1:0]       cfg_wlen_i,
  input  logic [1:0]       cfg_frame_i,
  input  logic             cfg_mdiv4_i,
  input  logic             smp_valid_i,
  output logic             smp_ready_o,
  input  logic [SMP_W-1:0] smp_left_i,
  input  logic [SMP_W-1:0] smp_right_i,
  input  logic             sck_i,
  input  logic             ws_i,
  output logic             sck_o,
  output logic             ws_o,
  output logic             clk_oe_o,
  output logic             sd_o,
  output logic             underflow_o
);
  logic shift_ev, ws_lvl, start, active, chan;
  cnt_t pos, slot;

  i2s_tx_clkgen u_clkgen (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .master_i   (cfg_master_i),
    .sck_inv_i  (cfg_sck_inv_i),
    .mdiv4_i    (cfg_mdiv4_i),
    .sck_i      (sck_i),
    .ws_i       (ws_i),
    .shift_ev_o (shift_ev),
    .sck_o      (sck_o),
    .ws_lvl_o   (ws_lvl)
  );

  i2s_tx_framer u_framer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .shift_ev_i  (shift_ev),
    .master_i    (cfg_master_i),
    .dly_i       (cfg_i2s_dly_i),
    .ws_inv_i    (cfg_ws_inv_i),
    .ws_lvl_i    (ws_lvl),
    .frame_sel_i (cfg_frame_i),
    .ws_o        (ws_o),
    .start_o     (start),
    .active_o    (active),
    .chan_o      (chan),
    .pos_o       (pos),
    .slot_o      (slot)
  );

  i2s_tx_shifter #(.SMP_W(SMP_W)) u_shifter (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .shift_ev_i  (shift_ev),
    .start_i     (start),
    .active_i    (active),
    .chan_i      (chan),
    .pos_i       (pos),
    .slot_i      (slot),
    .rjust_i     (cfg_rjust_i),
    .wlen_sel_i  (cfg_wlen_i),
    .valid_i     (smp_valid_i),
    .left_i      (smp_left_i),
    .right_i     (smp_right_i),
    .sd_o        (sd_o),
    .underflow_o (underflow_o)
  );

  assign smp_ready_o = start;
  assign clk_oe_o    = cfg_master_i;

  AST_READY_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_ready_o |=> !smp_ready_o); // R8
  AST_SLAVE_CLK_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_master_i |-> (!sck_o && !ws_o)); // R10
endmodule

// File: tb/tb_i2s_tx.sv
module tb_i2s_tx;
  localparam int SMP_W = 32;
  localparam int NV    = 6;
  localparam int LOG_N = 300;

  typedef struct packed {
    logic        dly;
    logic        rj;
    logic        wsi;
    logic        scki;
    logic [1:0]  wl;
    logic [1:0]  fs;
    logic        md;
    logic [31:0] al;
    logic [31:0] ar;
    logic [31:0] bl;
    logic [31:0] br;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 2'd1, 1'b0, 32'hDEAD_B00F, 32'h1234_8001, 32'hFFFF_7FFE, 32'h0F0F_C3A5},
    '{1'b0, 1'b0, 1'b1, 1'b1, 2'd1, 2'd1, 1'b1, 32'hAB96_1E2D, 32'h55C0_FFEE, 32'h0080_0001, 32'h77FF_FFFE},
    '{1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 2'd2, 1'b0, 32'h9999_8421, 32'h0000_F00D, 32'hCAFE_1357, 32'hBEEF_ACE1},
    '{1'b1, 1'b0, 1'b0, 1'b1, 2'd2, 2'd2, 1'b1, 32'h8000_0001, 32'h7FFF_FFFE, 32'hA5A5_5A5A, 32'h1357_9BDF},
    '{1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 32'h1111_C001, 32'h2222_3FFE, 32'h3333_9ABC, 32'h4444_0F0F},
    '{1'b0, 1'b1, 1'b1, 1'b0, 2'd1, 2'd1, 1'b0, 32'hEE80_0003, 32'h0112_3456, 32'h55FE_DCBA, 32'h0000_0001}
  };

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0;
  logic cfg_master = 1'b1, cfg_dly = 1'b0, cfg_rj = 1'b0, cfg_wsi = 1'b0, cfg_scki = 1'b0;
  logic [1:0] cfg_wl = 2'd0, cfg_fs = 2'd0;
  logic cfg_md = 1'b0;
  logic smp_valid = 1'b0;
  logic [SMP_W-1:0] smp_left = '0, smp_right = '0;
  logic sck_in = 1'b0, ws_in = 1'b1;
  logic smp_ready, sck_out, ws_out, clk_oe, sd, underflow;

  i2s_tx #(.SMP_W(SMP_W)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_master_i(cfg_master), .cfg_i2s_dly_i(cfg_dly), .cfg_rjust_i(cfg_rj),
    .cfg_ws_inv_i(cfg_wsi), .cfg_sck_inv_i(cfg_scki), .cfg_wlen_i(cfg_wl),
    .cfg_frame_i(cfg_fs), .cfg_mdiv4_i(cfg_md),
    .smp_valid_i(smp_valid), .smp_ready_o(smp_ready),
    .smp_left_i(smp_left), .smp_right_i(smp_right),
    .sck_i(sck_in), .ws_i(ws_in),
    .sck_o(sck_out), .ws_o(ws_out), .clk_oe_o(clk_oe),
    .sd_o(sd), .underflow_o(underflow)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  // monitor: decodes the line at the receiver sampling edge
  logic mon_en = 1'b0;
  int cap_n, last_cyc, per, edge_bad, hs, uf;
  logic r_prev, sd_prev;
  logic sd_log [LOG_N];
  logic ws_log [LOG_N];

  always @(negedge clk) begin
    logic r;
    r = sck_out ^ cfg_scki;
    if (!mon_en) begin
      cap_n = 0; last_cyc = 0; per = 0; edge_bad = 0; hs = 0; uf = 0;
    end else begin
      if (r && !r_prev) begin
        if (cap_n > 0 && cap_n <= LOG_N) begin
          sd_log[cap_n-1] = sd;
          ws_log[cap_n-1] = ws_out;
        end
        cap_n++;
        per = cyc - last_cyc;
        last_cyc = cyc;
      end
      if (sd !== sd_prev && !(r_prev && !r)) edge_bad++;
      if (smp_valid && smp_ready) hs++;
      if (underflow) uf++;
    end
    r_prev  = r;
    sd_prev = sd;
  end

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000 && !done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=<190000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic exp_bit(vec_t v, int k);
    int fl, s, w, g, q, p;
    logic [31:0] word;
    fl = 32 << v.fs;
    s  = fl / 2;
    w  = 16 + 8 * int'(v.wl);
    g  = k - int'(v.dly);
    if (g < 0 || g >= 2 * fl) return 1'b0;
    q = g % fl;
    p = q % s;
    if (g < fl) word = (q < s) ? v.al : v.ar;
    else        word = (q < s) ? v.bl : v.br;
    if (!v.rj) return (p < w) ? word[w-1-p] : 1'b0;
    return (p >= s - w) ? word[s-1-p] : 1'b0;
  endfunction

  task automatic wait_ready();
    do @(negedge clk); while (!smp_ready);
  endtask

  task automatic apply_cfg(vec_t v, logic master);
    mon_en = 1'b0;
    rst_n  = 1'b0;
    cfg_master = master; cfg_dly = v.dly; cfg_rj = v.rj; cfg_wsi = v.wsi;
    cfg_scki = v.scki; cfg_wl = v.wl; cfg_fs = v.fs; cfg_md = v.md;
    smp_valid = 1'b1; smp_left = v.al; smp_right = v.ar;
    repeat (3) @(posedge clk);
    @(negedge clk); mon_en = 1'b1;
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic run_vec(int i);
    vec_t v;
    int fl, bad_d, bad_w, first_k;
    logic act_b, exp_b;
    v = VECS[i];
    fl = 32 << v.fs;
    apply_cfg(v, 1'b1);
    wait_ready();
    @(posedge clk); #1 smp_left = v.bl; smp_right = v.br;
    wait_ready();
    @(posedge clk); #1 smp_valid = 1'b0;
    while (cap_n < 2 * fl + 3) @(negedge clk);
    bad_d = 0; bad_w = 0; first_k = -1; act_b = 1'b0; exp_b = 1'b0;
    for (int k = 0; k < 2 * fl + 2; k++) begin
      if (sd_log[k] !== exp_bit(v, k)) begin
        if (first_k < 0) begin first_k = k; act_b = sd_log[k]; exp_b = exp_bit(v, k); end
        bad_d++;
      end
      if (ws_log[k] !== (((k % fl) >= fl / 2) ^ v.wsi)) bad_w++;
    end
    chk(bad_d == 0, $sformatf("R5 R6 R7 R9 data stream vec%0d bit%0d", i, first_k), longint'(act_b), longint'(exp_b));
    chk(bad_w == 0, $sformatf("R2 R3 word clock vec%0d mismatches", i), bad_w, 0);
    chk(per == (v.md ? 4 : 2), $sformatf("R1 bit clock period vec%0d", i), per, v.md ? 4 : 2);
    chk(edge_bad == 0, $sformatf("R4 data edge vec%0d", i), edge_bad, 0);
    chk(hs == 2, $sformatf("R8 handshakes vec%0d", i), hs, 2);
    chk(uf == 1, $sformatf("R9 underflow pulses vec%0d", i), uf, 1);
    chk(clk_oe == 1'b1, $sformatf("R1 clock enable vec%0d", i), clk_oe, 1);
  endtask

  task automatic sbit(input logic w, output logic got);
    @(negedge clk); sck_in = 1'b0; ws_in = w;
    repeat (6) @(posedge clk);
    @(negedge clk); got = sd; sck_in = 1'b1;
    repeat (6) @(posedge clk);
  endtask

  initial begin
    vec_t sv;
    logic got, expb;
    int bad, p;

    // reset state, r11_
    cfg_master = 1'b1; cfg_scki = 1'b1; cfg_wsi = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(sd == 1'b0, "R11 sd in reset", sd, 0);
    chk(sck_out == 1'b1, "R11 sck follows polarity in reset", sck_out, 1);
    chk(ws_out == 1'b1, "R11 ws right level in reset", ws_out, 1);
    chk(underflow == 1'b0 && smp_ready == 1'b0, "R11 pulses low in reset",
        {underflow, smp_ready}, 0);

    // vector table walk
    for (int i = 0; i < NV; i++) run_vec(i);

    // slave mode: external clocks, start mid-frame
    sv = '{1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd1, 1'b0,
           32'hFFFF_A5C3, 32'h1234_3C5A, 32'h0, 32'h0};
    sck_in = 1'b0; ws_in = 1'b1;
    apply_cfg(sv, 1'b0);
    @(negedge clk);
    chk(clk_oe == 1'b0 && sck_out == 1'b0 && ws_out == 1'b0, "R10 slave clock outputs",
        {clk_oe, sck_out, ws_out}, 0);
    sck_in = 1'b1;
    repeat (6) @(posedge clk);
    bad = 0;
    for (int k = 0; k < 3; k++) begin
      sbit(1'b1, got);
      if (got !== 1'b0) bad++;
    end
    chk(bad == 0 && hs == 0, "R10 no frame before word clock edge", hs + bad, 0);
    bad = 0;
    for (int k = 0; k < 64; k++) begin
      sbit(k >= 32, got);
      p = k % 32;
      expb = (p < 16) ? ((k < 32) ? sv.al[15-p] : sv.ar[15-p]) : 1'b0;
      if (got !== expb) bad++;
    end
    chk(bad == 0, "R10 R7 slave frame data mismatches", bad, 0);
    chk(hs == 1, "R10 R8 slave handshakes", hs, 1);

    done = 1;
    summary();
    $finish;
  end
endmodule